// File: doc/BRIEF.md
# One-Wire Bus Master

This block is the bus-side engine of a one-wire master. It owns one open-drain line: it can pull the line low or let it float, and it watches the line level through a synchronizer. All of its durations are counted in pulses of a one-microsecond timing strobe. Each duration comes from a software-programmed field, and none is fixed in the hardware. Software loads two timing words, one for data slots and one for the reset/presence sequence. It then writes a control word to start exactly one action: a reset pulse with presence detection, a slot that writes a zero, or a slot that writes a one and reads back the bit a device returns.

When an action ends, the block returns to idle, which software sees through a status bit. The block also raises one of three event flags. Each flag stays set until software writes a one to its bit position. A flag drives the interrupt line only when its mask bit is set. Grouping bits into bytes, device addressing and error coding are left to software.

Top module: `onewire_master`

## Requirements
- R1: After reset the line is released, the status word reads ready (bit 0 = 1) with read bit 0, all event flags are clear and `irq` is low.
- R2: A control word with bit 30 and bit 2 set (bit 31 clear) starts a write-0 slot. The line goes low on the first strobe after the write and stays low for exactly `low0` strobes. Ready returns `slot + recov + setup` strobes after the falling strobe, and the slot-done flag (bit 13) is set.
- R3: A control word with bit 31 and bit 2 set starts a read slot. The line is held low for `low1` strobes. The line level seen `sample` strobes after the fall (for `sample` of 1 or more) is stored as the read bit in status bit 23. Ready and the slot-done flag follow the same rule as in R2.
- R4: A control word with bit 0 set and bits 31 and 30 clear starts a reset. The line is held low for `rst_low` strobes and then released for `rst_high` strobes, after which ready returns.
- R5: During a reset, if the line is seen low on any strobe among the first `win_hi + win_lo` strobes after release, the presence flag (bit 5) is set at the end. Otherwise the no-device flag (bit 0) is set. Exactly one of the two is set.
- R6: Decode priority is read over write-0 over reset. A word with bit 31 or bit 30 set but bit 2 clear starts nothing. A word with none of bits 31, 30 and 0 set starts nothing.
- R7: A control write that arrives while the block is not ready is ignored. The running action keeps its timing and outcome.
- R8: Writing the flag register (address 4) clears each flag whose data bit is 1 and leaves the others unchanged. Writing all ones clears every flag. An event and a clear in the same cycle leave the flag set.
- R9: `irq` is high exactly when some flag is set and its mask bit at the same position in the mask register (address 3) is set.
- R10: The ready bit reads 0 from the accepted control write until the action completes, and the line is never driven low while ready reads 1.

Register addresses: 0 control, 1 slot timing, 2 reset timing, 3 interrupt mask, 4 event flags, 5 status. Slot timing fields: `slot` [6:0], `low1` [10:7], `low0` [17:11], `sample` [21:18], `recov` [27:22], `setup` [29:28]. Reset timing fields: `rst_high` [8:0], `rst_low` [17:9], `win_hi` [23:18], `win_lo` [31:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1us | input | 1 | One-cycle strobe, once per microsecond, at least three clocks apart |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| bus_in | input | 1 | Line level, asynchronous |
| bus_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| irq | output | 1 | Masked event request |

## Verification
Some properties are checked on every cycle. The line is never pulled low while the block reports idle. Idle only ends through an accepted command, and commands are accepted only when idle. Presence and no-device outcomes never coincide. The slot-done flag rises only together with a return to idle and falls only after a write that clears it. Other behaviour needs the bench's scenarios with a modelled device on the line: the exact low and total durations measured in strobes, the value of the sampled read bit against device hold times before and after the sample point, presence pulses inside and outside the window, decode priority, and the mixing of flags, masks and partial clears.

// File: rtl/ow_pkg.sv
// Package ow_pkg
// Shared constants, register layout and types of the one-wire master.
// Assumes a 32-bit register word; bit positions below are decoded by software.
package ow_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 10;

    // register word addresses
    localparam int REG_CTRL = 0;
    localparam int REG_SLOT = 1;
    localparam int REG_RST  = 2;
    localparam int REG_MASK = 3;
    localparam int REG_FLAG = 4;
    localparam int REG_STAT = 5;

    // control word bits
    localparam int CTL_READ   = 31;
    localparam int CTL_WR0    = 30;
    localparam int CTL_SINGLE = 2;
    localparam int CTL_GO     = 0;

    // status word bits
    localparam int STS_RBIT  = 23;
    localparam int STS_READY = 0;

    // event flag positions; index 0 slot done, 1 presence, 2 no device
    localparam int NUM_FLAGS = 3;
    localparam int FLG_DONE  = 13;
    localparam int FLG_PRES  = 5;
    localparam int FLG_PERR  = 0;
    localparam int FLAG_POS [NUM_FLAGS] = '{FLG_DONE, FLG_PRES, FLG_PERR};

    typedef enum logic [1:0] {
        OP_NONE,
        OP_READ,
        OP_WR0,
        OP_RESET
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_SLOT,
        ST_RECOV,
        ST_RLOW,
        ST_RHIGH
    } seq_st_e;

    // slot timing word, bits [29:0]
    typedef struct packed {
        logic [1:0] setup;
        logic [5:0] recov;
        logic [3:0] sample;
        logic [6:0] low0;
        logic [3:0] low1;
        logic [6:0] slot;
    } slot_cfg_t;

    // reset timing word, bits [31:0]
    typedef struct packed {
        logic [7:0] win_lo;
        logic [5:0] win_hi;
        logic [8:0] rst_low;
        logic [8:0] rst_high;
    } rst_cfg_t;

    // Map a control word to the action it requests.
    function automatic op_e decode_ctl(input logic [WORD_W-1:0] w);
        op_e op;
        op = OP_NONE;
        if (w[CTL_READ] || w[CTL_WR0]) begin
            if (w[CTL_SINGLE]) op = w[CTL_READ] ? OP_READ : OP_WR0;
        end else if (w[CTL_GO]) begin
            op = OP_RESET;
        end
        return op;
    endfunction

endpackage

// File: rtl/ow_sync.sv
// Module ow_sync
// Multi-flop synchronizer for the asynchronous line level.
// Assumes STAGES >= 2; resets to the idle (released, high) level.
module ow_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sh_q;

    // shift the raw level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], din};
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/ow_regs.sv
// Module ow_regs
// Register file: timing words, mask, write-1-to-clear event flags,
// status read-back and command acceptance.
// Assumes one register access per cycle and combinational read data.
module ow_regs
    import ow_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic [WORD_W-1:0]   rdata,
    input  logic                ready,
    input  logic                rbit,
    input  logic                evt_done,
    input  logic                evt_pres,
    input  logic                evt_perr,
    output slot_cfg_t           slot_cfg,
    output rst_cfg_t            rst_cfg,
    output logic                cmd_start,
    output op_e                 cmd_op,
    output logic [WORD_W-1:0]   flags,
    output logic                irq
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_SLOT = ADDR_W'(REG_SLOT);
    localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(REG_RST);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(REG_MASK);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(REG_FLAG);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
    localparam int SLOT_BITS = $bits(slot_cfg_t);

    logic [NUM_FLAGS-1:0] evt_vec;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] mask_q;
    logic [WORD_W-1:0]    mask_word;
    logic [WORD_W-1:0]    stat_word;
    logic                 wr_flag;
    logic                 wr_mask;

    assign evt_vec = {evt_perr, evt_pres, evt_done};
    assign wr_flag = wr && (addr == A_FLAG);
    assign wr_mask = wr && (addr == A_MASK);

    // hold the two timing words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cfg <= '0;
            rst_cfg  <= '0;
        end else if (wr) begin
            if (addr == A_SLOT) slot_cfg <= slot_cfg_t'(wdata[SLOT_BITS-1:0]);
            if (addr == A_RST)  rst_cfg  <= rst_cfg_t'(wdata);
        end
    end

    // one flag and one mask bit per event, each at its own word position
    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
        localparam int POS = FLAG_POS[gi];
        logic f_q;
        logic m_q;

        // set on event (wins), clear on write-one, mask follows writes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                f_q <= 1'b0;
                m_q <= 1'b0;
            end else begin
                if (evt_vec[gi])                 f_q <= 1'b1;
                else if (wr_flag && wdata[POS])  f_q <= 1'b0;
                if (wr_mask)                     m_q <= wdata[POS];
            end
        end

        assign flag_q[gi] = f_q;
        assign mask_q[gi] = m_q;
    end

    // spread compact flag and mask bits to their word positions
    always_comb begin
        flags     = '0;
        mask_word = '0;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            flags[FLAG_POS[i]]     = flag_q[i];
            mask_word[FLAG_POS[i]] = mask_q[i];
        end
    end

    // status word layout
    always_comb begin
        stat_word            = '0;
        stat_word[STS_READY] = ready;
        stat_word[STS_RBIT]  = rbit;
    end

    // accept a meaningful control word only while idle
    assign cmd_op    = decode_ctl(wdata);
    assign cmd_start = wr && (addr == A_CTRL) && ready && (cmd_op != OP_NONE);

    assign irq = |(flag_q & mask_q);

    // read-back multiplexer
    always_comb begin
        if (addr == A_SLOT)      rdata = WORD_W'(slot_cfg);
        else if (addr == A_RST)  rdata = rst_cfg;
        else if (addr == A_MASK) rdata = mask_word;
        else if (addr == A_FLAG) rdata = flags;
        else if (addr == A_STAT) rdata = stat_word;
        else                     rdata = '0;
    end

endmodule

// File: rtl/ow_seq.sv
// Module ow_seq
// Bus sequencer: times reset/presence and data slots in microsecond strobes
// with one shared elapsed counter, drives the line low and samples it.
// Assumes tick strobes are one clock wide and at least three clocks apart,
// and that bus_s is already synchronized.
module ow_seq
    import ow_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      bus_s,
    input  logic      cmd_start,
    input  op_e       cmd_op,
    input  slot_cfg_t slot_cfg,
    input  rst_cfg_t  rst_cfg,
    output logic      ready,
    output logic      drive_low,
    output logic      rbit,
    output logic      evt_done,
    output logic      evt_pres,
    output logic      evt_perr
);

    seq_st_e           st_q;
    op_e               op_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nx;
    logic              rbit_q;
    logic              seen_q;

    logic [CNT_W-1:0]  low_len;
    logic [CNT_W-1:0]  slot_len;
    logic [CNT_W-1:0]  recov_len;
    logic [CNT_W-1:0]  win_len;
    logic              slot_end;
    logic              recov_end;
    logic              rlow_end;
    logic              rhigh_end;
    logic              low_now;
    logic              present;

    assign cnt_nx    = cnt_q + 1'b1;
    assign low_len   = (op_q == OP_READ) ? CNT_W'(slot_cfg.low1) : CNT_W'(slot_cfg.low0);
    assign slot_len  = CNT_W'(slot_cfg.slot);
    assign recov_len = CNT_W'(slot_cfg.recov) + CNT_W'(slot_cfg.setup);
    assign win_len   = CNT_W'(rst_cfg.win_hi) + CNT_W'(rst_cfg.win_lo);

    assign slot_end  = tick && (cnt_nx >= slot_len);
    assign recov_end = tick && (cnt_nx >= recov_len);
    assign rlow_end  = tick && (cnt_nx >= CNT_W'(rst_cfg.rst_low));
    assign rhigh_end = tick && (cnt_nx >= CNT_W'(rst_cfg.rst_high));
    assign low_now   = tick && (cnt_q < win_len) && !bus_s;
    assign present   = seen_q || low_now;

    // state, elapsed count, read bit and presence memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            op_q   <= OP_NONE;
            cnt_q  <= '0;
            rbit_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (cmd_start) begin
                        op_q <= cmd_op;
                        st_q <= ST_ARM;
                    end
                end
                ST_ARM: begin
                    if (tick) begin
                        cnt_q  <= '0;
                        seen_q <= 1'b0;
                        st_q   <= (op_q == OP_RESET) ? ST_RLOW : ST_SLOT;
                    end
                end
                ST_SLOT: begin
                    if (tick) begin
                        cnt_q <= cnt_nx;
                        if (op_q == OP_READ && cnt_nx == CNT_W'(slot_cfg.sample))
                            rbit_q <= bus_s;
                        if (slot_end) begin
                            cnt_q <= '0;
                            st_q  <= (recov_len == '0) ? ST_IDLE : ST_RECOV;
                        end
                    end
                end
                ST_RECOV: begin
                    if (tick) begin
                        cnt_q <= cnt_nx;
                        if (recov_end) st_q <= ST_IDLE;
                    end
                end
                ST_RLOW: begin
                    if (tick) begin
                        cnt_q <= cnt_nx;
                        if (rlow_end) begin
                            cnt_q <= '0;
                            st_q  <= ST_RHIGH;
                        end
                    end
                end
                ST_RHIGH: begin
                    if (tick) begin
                        cnt_q <= cnt_nx;
                        if (low_now)   seen_q <= 1'b1;
                        if (rhigh_end) st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // line drive and completion events, derived from registered state
    always_comb begin
        drive_low = ((st_q == ST_SLOT) && (cnt_q < low_len)) || (st_q == ST_RLOW);
        evt_done  = ((st_q == ST_SLOT) && slot_end && (recov_len == '0)) ||
                    ((st_q == ST_RECOV) && recov_end);
        evt_pres  = (st_q == ST_RHIGH) && rhigh_end && present;
        evt_perr  = (st_q == ST_RHIGH) && rhigh_end && !present;
    end

    assign ready = (st_q == ST_IDLE);
    assign rbit  = rbit_q;

endmodule

// File: rtl/onewire_master.sv
// Module onewire_master
// Top of the one-wire master: register file, input synchronizer and
// bus sequencer. The line output is open-drain: 1 pulls low, 0 releases.
// Assumes tick_1us is a one-clock strobe at 1 MHz, three or more clocks apart.
module onewire_master
    import ow_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1us,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              bus_in,
    output logic              bus_drive_low,
    output logic              irq
);

    slot_cfg_t          slot_cfg;
    rst_cfg_t           rst_cfg;
    op_e                cmd_op;
    logic               cmd_start;
    logic               seq_ready;
    logic               seq_rbit;
    logic               evt_done;
    logic               evt_pres;
    logic               evt_perr;
    logic               bus_s;
    logic [WORD_W-1:0]  flag_vec;

    // bring the line level into the clock domain
    ow_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (bus_in),
        .dout  (bus_s)
    );

    // software-visible registers
    ow_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .ready     (seq_ready),
        .rbit      (seq_rbit),
        .evt_done  (evt_done),
        .evt_pres  (evt_pres),
        .evt_perr  (evt_perr),
        .slot_cfg  (slot_cfg),
        .rst_cfg   (rst_cfg),
        .cmd_start (cmd_start),
        .cmd_op    (cmd_op),
        .flags     (flag_vec),
        .irq       (irq)
    );

    // bus timing engine
    ow_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_1us),
        .bus_s     (bus_s),
        .cmd_start (cmd_start),
        .cmd_op    (cmd_op),
        .slot_cfg  (slot_cfg),
        .rst_cfg   (rst_cfg),
        .ready     (seq_ready),
        .drive_low (bus_drive_low),
        .rbit      (seq_rbit),
        .evt_done  (evt_done),
        .evt_pres  (evt_pres),
        .evt_perr  (evt_perr)
    );

endmodule

// File: rtl/ow_checker.sv
// Module ow_checker
// Cycle-level properties of the one-wire master, attached by bind.
// Assumes the signal meanings of onewire_master's internal nets.
module ow_checker #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              drive_low,
    input logic              cmd_start,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              clr_done_bit,
    input logic              flag_done,
    input logic              evt_pres,
    input logic              evt_perr
);

    // R1: reset leaves the block idle with the line released
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (ready && !drive_low));

    // R10: the line is only pulled while an action runs
    a_r10_low_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> !ready);

    // R7: commands are accepted only while idle
    a_r7_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> ready);

    // R10: idle ends only through an accepted command
    a_r10_busy_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(cmd_start));

    // R5: presence and no-device never reported together
    a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_pres && evt_perr));

    // R2: the slot-done flag rises together with the return to idle
    a_r2_done_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_done) |-> ready);

    // R8: the slot-done flag falls only after a clearing write
    a_r8_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_done) |->
            $past(reg_wr && (reg_addr == ADDR_W'(ow_pkg::REG_FLAG)) && clr_done_bit));

endmodule

bind onewire_master ow_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ready        (seq_ready),
    .drive_low    (bus_drive_low),
    .cmd_start    (cmd_start),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .clr_done_bit (reg_wdata[ow_pkg::FLG_DONE]),
    .flag_done    (flag_vec[ow_pkg::FLG_DONE]),
    .evt_pres     (evt_pres),
    .evt_perr     (evt_perr)
);

// File: tb/sim_onewire_master.sv
// Bench for onewire_master: a vector table walked by one loop, then directed
// tests. A device model pulls the line low over a window counted in strobes
// after the master's falling strobe.
module sim_onewire_master;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int AW         = 3;
    localparam int WAIT_LIM   = 20000;

    localparam logic [31:0] C_WR0  = 32'h4000_0004;
    localparam logic [31:0] C_RD   = 32'h8000_0004;
    localparam logic [31:0] C_BOTH = 32'hC000_0004;
    localparam logic [31:0] C_RST  = 32'h0000_0001;
    // reset word: win_lo 10, win_hi 5, rst_low 20, rst_high 40
    localparam logic [31:0] RST_WORD = (32'd10 << 24) | (32'd5 << 18) | (32'd20 << 9) | 32'd40;

    typedef struct packed {
        logic [31:0] ctl;
        logic [31:0] tsu, trel, trdv, tl0, tl1, tsl;
        logic [31:0] sst, slen;
        logic [31:0] elow, edur, eflag, erbit;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{C_WR0,  1, 3, 12, 50, 5, 60,  0,  0, 50, 64, 32'h2000, 2}, // R2 long
        '{C_WR0,  0, 0,  6,  4, 2, 10,  0,  0,  4, 10, 32'h2000, 2}, // R2 no recovery
        '{C_RD,   1, 2,  6,  8, 2, 20,  0,  0,  2, 23, 32'h2000, 1}, // R3 no device
        '{C_RD,   1, 2,  6,  8, 2, 20,  0, 10,  2, 23, 32'h2000, 0}, // R3 device holds low
        '{C_RD,   1, 2,  6,  8, 2, 20,  0,  3,  2, 23, 32'h2000, 1}, // R3 device lets go early
        '{C_BOTH, 1, 2,  6,  8, 2, 20,  0,  0,  2, 23, 32'h2000, 1}, // R6 read wins
        '{C_RST,  0, 0,  0,  0, 0,  0, 24,  6, 20, 60, 32'h0020, 2}, // R4 R5 present
        '{C_RST,  0, 0,  0,  0, 0,  0,  0,  0, 20, 60, 32'h0001, 2}, // R5 nobody
        '{C_RST,  0, 0,  0,  0, 0,  0, 40, 10, 20, 60, 32'h0001, 2}  // R5 late pulse
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic bus_drive_low;
    logic irq;
    logic slave_low = 1'b0;
    logic bus_in;

    assign bus_in = !(bus_drive_low || slave_low);

    int n_chk = 0;
    int n_fail = 0;
    bit armed = 0;
    bit started = 0;
    int k = 0;
    int lowc = 0;
    int s_start = 0;
    int s_len = 0;
    int drv_seen = 0;

    onewire_master #(.ADDR_W(AW), .SYNC_STAGES(2)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_1us      (tick),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .bus_in        (bus_in),
        .bus_drive_low (bus_drive_low),
        .irq           (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // strobe generator, changes only on falling edges
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div  = (div + 1) % TICK_DIV;
            tick = (div == 0);
        end
    end

    // strobe-domain monitor and device model, just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (bus_drive_low) drv_seen++;
            if (tick && armed) begin
                if (!started) begin
                    if (bus_drive_low) begin
                        started = 1;
                        k = 0;
                        lowc = 1;
                    end
                end else begin
                    k++;
                    if (bus_drive_low) lowc++;
                end
                slave_low = started && (k >= s_start) && (k < s_start + s_len);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = AW'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_reg(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic start_op(input logic [31:0] ctl, input int ss, input int sl);
        armed     = 0;
        started   = 0;
        slave_low = 0;
        s_start   = ss;
        s_len     = sl;
        armed     = 1;
        wr_reg(0, ctl);
    endtask

    task automatic finish_op(input string tag, output int low, output int dur);
        bit done = 0;
        low = -1;
        dur = -1;
        @(negedge clk);
        reg_addr = AW'(5);
        for (int i = 0; i < WAIT_LIM && !done; i++) begin
            @(posedge clk);
            #2;
            if (started && reg_rdata[0]) begin
                done = 1;
                low  = lowc;
                dur  = k;
            end
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL %s actual=busy expected=ready", tag);
        end
        armed     = 0;
        slave_low = 0;
    endtask

    function automatic logic [31:0] slot_word(input vec_t v);
        return (v.tsu << 28) | (v.trel << 22) | (v.trdv << 18) |
               (v.tl0 << 11) | (v.tl1 << 7) | v.tsl;
    endfunction

    initial begin
        logic [31:0] r;
        int low;
        int dur;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        rd_reg(5, r);
        chk("R1 status", r, 32'h1);
        rd_reg(4, r);
        chk("R1 flags", r, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 line", {31'b0, bus_drive_low}, 32'h0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            string tg;
            tg = $sformatf("vec%0d", v);
            wr_reg(1, slot_word(VEC[v]));
            wr_reg(2, RST_WORD);
            wr_reg(3, 32'h0);
            wr_reg(4, 32'hFFFF_FFFF);
            start_op(VEC[v].ctl, int'(VEC[v].sst), int'(VEC[v].slen));
            finish_op(tg, low, dur);
            chk({tg, " R2/R3/R4 low strobes"}, low, VEC[v].elow);
            chk({tg, " R2/R4 total strobes"}, dur, VEC[v].edur);
            rd_reg(4, r);
            chk({tg, " R2/R5 flags"}, r, VEC[v].eflag);
            if (VEC[v].erbit != 2) begin
                rd_reg(5, r);
                chk({tg, " R3 read bit"}, {31'b0, r[23]}, VEC[v].erbit);
            end
        end

        // R6: words that request nothing
        wr_reg(4, 32'hFFFF_FFFF);
        drv_seen = 0;
        wr_reg(0, 32'h0000_0004);
        wr_reg(0, 32'h4000_0000);
        wr_reg(0, 32'h8000_0000);
        repeat (20 * TICK_DIV) @(posedge clk);
        chk("R6 no drive", drv_seen, 0);
        rd_reg(5, r);
        chk("R6 still ready", {31'b0, r[0]}, 32'h1);
        rd_reg(4, r);
        chk("R6 no flags", r, 32'h0);

        // R7/R10: command while busy is ignored, ready reads 0 meanwhile
        wr_reg(1, slot_word(VEC[0]));
        start_op(C_WR0, 0, 0);
        repeat (10 * TICK_DIV) @(posedge clk);
        rd_reg(5, r);
        chk("R10 busy status", {31'b0, r[0]}, 32'h0);
        wr_reg(0, C_RST);
        finish_op("R7", low, dur);
        chk("R7 low kept", low, 50);
        chk("R7 length kept", dur, 64);
        rd_reg(4, r);
        chk("R7 only done flag", r, 32'h2000);

        // R8: partial and full clears
        wr_reg(4, 32'hFFFF_FFFF);
        start_op(C_RST, 0, 0);
        finish_op("R8 rst", low, dur);
        wr_reg(1, slot_word(VEC[1]));
        start_op(C_WR0, 0, 0);
        finish_op("R8 wr0", low, dur);
        rd_reg(4, r);
        chk("R8 both flags", r, 32'h2001);
        wr_reg(4, 32'h2000);
        rd_reg(4, r);
        chk("R8 partial clear", r, 32'h0001);
        wr_reg(4, 32'h0);
        rd_reg(4, r);
        chk("R8 zero write", r, 32'h0001);

        // R9: masking
        wr_reg(3, 32'h0);
        #1;
        chk("R9 all masked", {31'b0, irq}, 32'h0);
        wr_reg(3, 32'h2000);
        #1;
        chk("R9 other mask", {31'b0, irq}, 32'h0);
        wr_reg(3, 32'h0001);
        #1;
        chk("R9 enabled", {31'b0, irq}, 32'h1);
        wr_reg(4, 32'hFFFF_FFFF);
        rd_reg(4, r);
        chk("R8 full clear", r, 32'h0);
        chk("R9 cleared", {31'b0, irq}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule